// File: doc/BRIEF.md
# Readout Protection Level Controller

This block keeps the device's readout protection level and rules on every access to protected memory. The level lives in a three-state machine: `LVL0` (open, the factory and reset default), `LVL1` (memories shielded from untrusted contexts, debug still usable) and `LVL2` (permanent lock). The named transitions are: `open_to_shield` (LVL0→LVL1), `open_to_lock` (LVL0→LVL2), `shield_to_lock` (LVL1→LVL2), `regress` (LVL1→LVL0, which raises a mass-erase pulse), and `load` (a copy of the stored option level is taken in on a load strobe). Every other request is `reject`. It leaves the level as it was and raises an error pulse.

Each access descriptor gives a target region and an operation. The controller answers allow or deny one cycle later. The answer depends on the level, on whether the part booted from user flash, and on whether a debugger is attached. An access to user flash, backup registers or SRAM2 from an untrusted context at a protected level sets a fault. The fault stays set until power-on reset, and while it is set every access is denied. At the top level the controller turns off the debug port, forces boot to user flash and locks option writes.

Top module: `rdp_guard`

## Requirements
- R1: After reset, `cur_level` is 0, `fault`, `mass_erase` and `chg_err` are low, `dbg_en` is high, and `boot_forced` and `opt_lock` are low. Level codes are 00 = L0, 01 = L1 and 10 = L2.
- R2: A change request with `chg_code` moves L0 to L1 (01) or L2 (10), and moves L1 to L0 (00) or L2 (10). The new level shows on `cur_level` in the cycle after the request.
- R3: These requests are rejected: any request at L2, a request for the current level, and the code 11. A rejected request gives a one-cycle `chg_err` pulse and leaves the level unchanged.
- R4: `mass_erase` pulses for exactly one cycle on an L1→L0 move. It pulses on no other event.
- R5: `ob_load` copies `ob_code` into the level and maps code 11 to L1. It takes priority over a change request in the same cycle. At L2 it is ignored. A load never raises `mass_erase` or `chg_err`.
- R6: At L0 every read (op 0), write (op 1) or erase (op 2) to a valid region is allowed, whatever the boot source or debugger flag. Valid regions are 0 user flash, 1 backup, 2 SRAM2, 3 system flash and 4 option bytes.
- R7: At L1 with a trusted context (user-flash boot, no debugger), regions 0–2 allow all operations, system flash allows only reads, and option bytes allow all operations.
- R8: At L1 with an untrusted context, an access to regions 0–2 is denied and sets `fault`. System flash allows only reads, and a denied write there does not set `fault`. Option bytes allow all operations.
- R9: At L2, `dbg_en` is low and `boot_forced` and `opt_lock` are high. The debugger flag and the boot input have no effect, so the context is trusted. Regions 0–2 are fully open, and system flash and option bytes are read-only.
- R10: Once `fault` is set it stays set until reset, and every access answered while it is set is denied.
- R11: `resp_valid` follows `acc_valid` by one cycle. Op code 3 and regions 5–7 are always denied and never set `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| ob_load | input | 1 | Load the stored option level |
| ob_code | input | 2 | Stored level code to load |
| chg_req | input | 1 | Level change request |
| chg_code | input | 2 | Requested level code |
| boot_uflash | input | 1 | 1 when booting from user flash |
| dbg_attached | input | 1 | Debugger presence flag |
| acc_valid | input | 1 | Access descriptor valid |
| acc_region | input | 3 | Target region code |
| acc_op | input | 2 | Operation code: 0 read, 1 write, 2 erase |
| cur_level | output | 2 | Current level code |
| resp_valid | output | 1 | Decision valid |
| resp_allow | output | 1 | Access allowed |
| fault | output | 1 | Latched fault, halts execution |
| mass_erase | output | 1 | One-cycle mass-erase request |
| chg_err | output | 1 | One-cycle rejected-request pulse |
| dbg_en | output | 1 | Debug port enable |
| boot_forced | output | 1 | Boot forced to user flash |
| opt_lock | output | 1 | Option-byte write lock |

## Verification
A wrong level state shows on `cur_level`, `dbg_en`, `boot_forced` and `opt_lock` in the cycle right after the faulty transition. It also shows in the next answer that depends on the level. A bad regression shows as a missing or doubled `mass_erase` pulse one cycle after the request. A lost or wrongly set fault shows on the `fault` pin at the same edge as the offending decision. It also shows on the answer to the very next access, which must be denied.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
    localparam int LVL_W = 2;
    localparam int REG_W = 3;
    localparam int OP_W  = 2;

    typedef enum logic [LVL_W-1:0] {
        LVL0 = 2'b00,
        LVL1 = 2'b01,
        LVL2 = 2'b10
    } rdp_lvl_e;

    localparam logic [REG_W-1:0] RG_UFLASH = 3'd0;
    localparam logic [REG_W-1:0] RG_BKP    = 3'd1;
    localparam logic [REG_W-1:0] RG_SRAM2  = 3'd2;
    localparam logic [REG_W-1:0] RG_SYSF   = 3'd3;
    localparam logic [REG_W-1:0] RG_OPT    = 3'd4;

    localparam logic [OP_W-1:0] OP_RD = 2'd0;
    localparam logic [OP_W-1:0] OP_WR = 2'd1;
    localparam logic [OP_W-1:0] OP_ER = 2'd2;

    // Unknown codes map to the middle level so a corrupted copy stays protected.
    function automatic rdp_lvl_e decode_lvl(input logic [LVL_W-1:0] code);
        case (code)
            2'b00:   return LVL0;
            2'b10:   return LVL2;
            default: return LVL1;
        endcase
    endfunction
endpackage

// File: rtl/rdp_level_fsm.sv
module rdp_level_fsm
    import rdp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ob_load,
    input  logic [LVL_W-1:0] ob_code,
    input  logic             chg_req,
    input  logic [LVL_W-1:0] chg_code,
    output rdp_lvl_e         state,
    output logic             mass_erase,
    output logic             chg_err
);
    rdp_lvl_e nxt;
    logic     erase_n;
    logic     err_n;

    always_comb begin
        nxt     = state;
        erase_n = 1'b0;
        err_n   = 1'b0;
        if (ob_load) begin
            if (state != LVL2) nxt = decode_lvl(ob_code);
        end else if (chg_req) begin
            unique case (state)
                LVL0: begin
                    if (chg_code == 2'b01)      nxt = LVL1;
                    else if (chg_code == 2'b10) nxt = LVL2;
                    else                        err_n = 1'b1;
                end
                LVL1: begin
                    if (chg_code == 2'b00) begin
                        nxt     = LVL0;
                        erase_n = 1'b1;
                    end else if (chg_code == 2'b10) begin
                        nxt = LVL2;
                    end else begin
                        err_n = 1'b1;
                    end
                end
                LVL2: err_n = 1'b1;
                default: nxt = LVL1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LVL0;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mass_erase <= 1'b0;
            chg_err    <= 1'b0;
        end else begin
            mass_erase <= erase_n;
            chg_err    <= err_n;
        end
    end

    // R2
    lvl2_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == LVL2 |=> state == LVL2);
    // R4
    erase_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mass_erase |=> !mass_erase);
    // R4
    erase_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mass_erase |-> (state == LVL0 && $past(state) == LVL1));
    // R3
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_err |-> state == $past(state));
endmodule

// File: rtl/rdp_access_policy.sv
module rdp_access_policy
    import rdp_pkg::*;
(
    input  rdp_lvl_e         level,
    input  logic             boot_uf,
    input  logic             dbg,
    input  logic [REG_W-1:0] region,
    input  logic [OP_W-1:0]  op,
    output logic             allow,
    output logic             viol
);
    logic trusted;
    logic rd;
    logic op_ok;
    logic prot;
    logic rg_ok;

    always_comb begin
        trusted = boot_uf && !dbg;
        rd      = (op == OP_RD);
        op_ok   = rd || (op == OP_WR) || (op == OP_ER);
        prot    = (region == RG_UFLASH) || (region == RG_BKP) || (region == RG_SRAM2);
        rg_ok   = (region <= RG_OPT);
        allow   = 1'b0;
        viol    = 1'b0;
        if (op_ok && rg_ok) begin
            unique case (level)
                LVL0: allow = 1'b1;
                LVL1: begin
                    if (prot) begin
                        allow = trusted;
                        viol  = !trusted;
                    end else if (region == RG_SYSF) begin
                        allow = rd;
                    end else begin
                        allow = 1'b1;
                    end
                end
                LVL2: begin
                    if (prot) begin
                        allow = trusted;
                        viol  = !trusted;
                    end else begin
                        allow = rd;
                    end
                end
                default: allow = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/rdp_fault_latch.sv
module rdp_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    output logic fault
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   fault <= 1'b0;
        else if (set) fault <= 1'b1;
    end

    // R10
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);
endmodule

// File: rtl/rdp_guard.sv
module rdp_guard
    import rdp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ob_load,
    input  logic [1:0]       ob_code,
    input  logic             chg_req,
    input  logic [1:0]       chg_code,
    input  logic             boot_uflash,
    input  logic             dbg_attached,
    input  logic             acc_valid,
    input  logic [2:0]       acc_region,
    input  logic [1:0]       acc_op,
    output logic [1:0]       cur_level,
    output logic             resp_valid,
    output logic             resp_allow,
    output logic             fault,
    output logic             mass_erase,
    output logic             chg_err,
    output logic             dbg_en,
    output logic             boot_forced,
    output logic             opt_lock
);
    rdp_lvl_e level;
    logic     pol_allow;
    logic     pol_viol;
    logic     eff_dbg;
    logic     eff_boot;

    rdp_level_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ob_load   (ob_load),
        .ob_code   (ob_code),
        .chg_req   (chg_req),
        .chg_code  (chg_code),
        .state     (level),
        .mass_erase(mass_erase),
        .chg_err   (chg_err)
    );

    always_comb begin
        dbg_en      = (level != LVL2);
        boot_forced = (level == LVL2);
        opt_lock    = (level == LVL2);
        eff_dbg     = dbg_attached && dbg_en;
        eff_boot    = boot_uflash || boot_forced;
        cur_level   = level;
    end

    rdp_access_policy u_pol (
        .level  (level),
        .boot_uf(eff_boot),
        .dbg    (eff_dbg),
        .region (acc_region),
        .op     (acc_op),
        .allow  (pol_allow),
        .viol   (pol_viol)
    );

    rdp_fault_latch u_flt (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (acc_valid && pol_viol),
        .fault(fault)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_allow <= 1'b0;
        end else begin
            resp_valid <= acc_valid;
            resp_allow <= acc_valid && pol_allow && !fault;
        end
    end

    // R11
    resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> resp_valid);
    // R10
    faulted_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && acc_valid) |=> !resp_allow);
    // R9
    l2_opt_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && level == LVL2 && acc_region == RG_OPT && acc_op != OP_RD) |=> !resp_allow);
endmodule

// File: tb/rdp_guard_bench.sv
module rdp_guard_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ob_load, chg_req, boot_uflash, dbg_attached, acc_valid;
    logic [1:0] ob_code, chg_code, acc_op;
    logic [2:0] acc_region;
    logic [1:0] cur_level;
    logic       resp_valid, resp_allow, fault, mass_erase, chg_err;
    logic       dbg_en, boot_forced, opt_lock;

    int errors = 0;
    int checks = 0;
    int m_lvl  = 0;
    bit m_flt  = 0;

    always #10 clk = ~clk;

    rdp_guard u_rdp_guard (
        .clk(clk), .rst_n(rst_n), .ob_load(ob_load), .ob_code(ob_code),
        .chg_req(chg_req), .chg_code(chg_code), .boot_uflash(boot_uflash),
        .dbg_attached(dbg_attached), .acc_valid(acc_valid), .acc_region(acc_region),
        .acc_op(acc_op), .cur_level(cur_level), .resp_valid(resp_valid),
        .resp_allow(resp_allow), .fault(fault), .mass_erase(mass_erase),
        .chg_err(chg_err), .dbg_en(dbg_en), .boot_forced(boot_forced), .opt_lock(opt_lock)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_allow(int lv, bit boot, bit dbg, int rg, int op);
        bit trusted;
        trusted = (lv == 2) ? 1'b1 : (boot && !dbg);
        if (op == 3 || rg > 4) return 1'b0;
        if (lv == 0) return 1'b1;
        if (rg <= 2) return trusted;
        if (rg == 3) return op == 0;
        return (lv == 1) || (op == 0);
    endfunction

    function automatic bit exp_viol(int lv, bit boot, bit dbg, int rg, int op);
        bit trusted;
        trusted = (lv == 2) ? 1'b1 : (boot && !dbg);
        return (lv != 0) && (rg <= 2) && (op != 3) && !trusted;
    endfunction

    task automatic access(input string req, input int rg, input int op);
        bit ea;
        ea = exp_allow(m_lvl, boot_uflash, dbg_attached, rg, op) && !m_flt;
        if (exp_viol(m_lvl, boot_uflash, dbg_attached, rg, op)) m_flt = 1'b1;
        acc_valid  = 1'b1;
        acc_region = 3'(rg);
        acc_op     = 2'(op);
        @(posedge clk); #1;
        acc_valid = 1'b0;
        chk(req, "resp_valid", int'(resp_valid), 1);
        chk(req, $sformatf("resp_allow rg%0d op%0d", rg, op), int'(resp_allow), int'(ea));
        chk(req, "fault", int'(fault), int'(m_flt));
    endtask

    task automatic change(input string req, input int code, input int exp_lvl,
                          input bit exp_er, input bit exp_err);
        chg_req  = 1'b1;
        chg_code = 2'(code);
        @(posedge clk); #1;
        chg_req = 1'b0;
        m_lvl = exp_lvl;
        chk(req, "cur_level", int'(cur_level), exp_lvl);
        chk(req, "mass_erase", int'(mass_erase), int'(exp_er));
        chk(req, "chg_err", int'(chg_err), int'(exp_err));
        @(posedge clk); #1;
        chk(req, "mass_erase drop", int'(mass_erase), 0);
        chk(req, "chg_err drop", int'(chg_err), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        m_lvl = 0;
        m_flt = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "cur_level", int'(cur_level), 0);
        chk("R1", "fault", int'(fault), 0);
        chk("R1", "mass_erase", int'(mass_erase), 0);
        chk("R1", "chg_err", int'(chg_err), 0);
        chk("R1", "dbg_en", int'(dbg_en), 1);
        chk("R1", "boot_forced", int'(boot_forced), 0);
        chk("R1", "opt_lock", int'(opt_lock), 0);
    endtask

    task automatic t_open();
        boot_uflash = 1'b0; dbg_attached = 1'b1;
        for (int rg = 0; rg < 5; rg++)
            for (int op = 0; op < 3; op++) access("R6", rg, op);
        boot_uflash = 1'b1; dbg_attached = 1'b0;
    endtask

    task automatic t_shield_trusted();
        change("R2", 1, 1, 1'b0, 1'b0);
        for (int rg = 0; rg < 5; rg++)
            for (int op = 0; op < 3; op++) access("R7", rg, op);
    endtask

    task automatic t_regress_reject();
        change("R4", 0, 0, 1'b1, 1'b0);
        change("R3", 0, 0, 1'b0, 1'b1);
        change("R3", 3, 0, 1'b0, 1'b1);
    endtask

    task automatic t_load();
        ob_load = 1'b1; ob_code = 2'b11;
        @(posedge clk); #1;
        ob_load = 1'b0; m_lvl = 1;
        chk("R5", "invalid code -> L1", int'(cur_level), 1);
        chk("R5", "no erase", int'(mass_erase), 0);
        ob_load = 1'b1; ob_code = 2'b00; chg_req = 1'b1; chg_code = 2'b10;
        @(posedge clk); #1;
        ob_load = 1'b0; chg_req = 1'b0; m_lvl = 0;
        chk("R5", "load wins over request", int'(cur_level), 0);
        chk("R5", "load gives no erase", int'(mass_erase), 0);
        chk("R5", "load gives no err", int'(chg_err), 0);
    endtask

    task automatic t_untrusted();
        change("R2", 1, 1, 1'b0, 1'b0);
        dbg_attached = 1'b1;
        access("R8", 3, 0);
        access("R8", 3, 1);
        access("R8", 4, 1);
        access("R8", 4, 2);
        access("R11", 0, 3);
        access("R11", 6, 0);
        access("R8", 1, 0);
        access("R10", 4, 0);
        access("R10", 3, 0);
        change("R10", 0, 0, 1'b1, 1'b0);
        chk("R10", "fault held across level change", int'(fault), 1);
        dbg_attached = 1'b0;
        boot_uflash  = 1'b1;
        access("R10", 0, 0);
        do_reset();
        chk("R10", "fault cleared by reset", int'(fault), 0);
        chk("R1", "level after reset", int'(cur_level), 0);
    endtask

    task automatic t_lock();
        change("R2", 1, 1, 1'b0, 1'b0);
        change("R2", 2, 2, 1'b0, 1'b0);
        chk("R9", "dbg_en", int'(dbg_en), 0);
        chk("R9", "boot_forced", int'(boot_forced), 1);
        chk("R9", "opt_lock", int'(opt_lock), 1);
        dbg_attached = 1'b1; boot_uflash = 1'b0;
        for (int rg = 0; rg < 5; rg++)
            for (int op = 0; op < 3; op++) access("R9", rg, op);
        access("R11", 2, 3);
        change("R3", 0, 2, 1'b0, 1'b1);
        change("R3", 1, 2, 1'b0, 1'b1);
        ob_load = 1'b1; ob_code = 2'b00;
        @(posedge clk); #1;
        ob_load = 1'b0;
        chk("R5", "load ignored at L2", int'(cur_level), 2);
    endtask

    initial begin
        rst_n = 1'b0; ob_load = 1'b0; chg_req = 1'b0; ob_code = 2'b00; chg_code = 2'b00;
        boot_uflash = 1'b1; dbg_attached = 1'b0; acc_valid = 1'b0;
        acc_region = 3'd0; acc_op = 2'd0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_open();
        t_shield_trusted();
        t_regress_reject();
        t_load();
        t_untrusted();
        t_lock();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule